// File: doc/BRIEF.md
# Parallel Display Timing Generator

This block produces the raster timing for a parallel pixel interface: active-high horizontal and vertical sync, a data-enable, single-cycle strobes on the first and last visible pixel of a frame, and a one-cycle vertical event for interrupt logic. Each axis is set by one packed word that holds the sync width, back porch and front porch. A separate packed word holds the visible width and height. Pixel data and the pixel clock come from elsewhere. The block runs on the pixel clock.

Each axis walks through the same order: sync, back porch, visible region, front porch. The four words are copied into shadow storage only at a frame boundary, so software can rewrite them at any time without tearing a frame. A pause request, when enabled, lets the current frame finish and then holds the raster at its origin until the request is withdrawn. A tearing-effect path picks one of two sources, the external pad or the core-side signal. It synchronizes that source and turns each rising edge into a single-cycle event.

Top module: `dtg_top`

## Requirements
- R1: While reset is asserted, and for the two synchronizer cycles plus one setup cycle after it is released, every timing output and `paused` is low. The first counted raster cycle follows the third rising clock edge after release.
- R2: `h_timing` bits [7:0] give the horizontal sync width, bits [19:8] the back porch and bits [31:20] the front porch. `size_word` bits [15:0] give the visible width. A line lasts the sum of these four values, in the order sync, back porch, visible, front porch. `hsync` is high for the first sync-width cycles of every line.
- R3: `v_timing` uses the same bit layout, counted in lines. `size_word` bits [31:16] give the visible height. `vsync` is high for the first sync-width lines of every frame.
- R4: `de` is high only when both the horizontal and the vertical position are inside their visible regions.
- R5: `vsync_evt` is high for exactly one cycle, on the first cycle of every frame, which is also the first cycle of vertical sync.
- R6: `frame_start` pulses on the first visible pixel of a frame and `frame_end` on the last one. This also holds when a porch width is zero.
- R7: The size and timing words are sampled only on the last cycle of a frame, in the setup cycle and while paused. A change made in mid-frame takes effect from the next frame.
- R8: With `halt_en` and `halt_req` both high, the frame in progress completes. Then `paused` goes high and every timing output stays low. One cycle after the request is withdrawn, the raster restarts at its origin with `vsync_evt`.
- R9: With `halt_en` low, `halt_req` has no effect and frames keep running back to back.
- R10: With `te_en` high, a rising edge on the selected tearing-effect source gives a one-cycle `te_evt`. The source is `te_pad` when `te_src_pad` is 1 and `te_core` when it is 0. The event appears after the second rising clock edge following the input change. A held level does not repeat the event, and the unselected source is ignored.
- R11: With `te_en` low, no `te_evt` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_word | input | 32 | Visible height [31:16], visible width [15:0] |
| h_timing | input | 32 | Horizontal front porch [31:20], back porch [19:8], sync [7:0] |
| v_timing | input | 32 | Vertical front porch [31:20], back porch [19:8], sync [7:0] |
| halt_en | input | 1 | Enables the pause function |
| halt_req | input | 1 | Requests a pause at the next frame end |
| te_en | input | 1 | Enables tearing-effect events |
| te_src_pad | input | 1 | 1 selects the pad source, 0 the core source |
| te_pad | input | 1 | Tearing-effect signal from the external pad |
| te_core | input | 1 | Tearing-effect signal from inside the chip |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| vsync_evt | output | 1 | One-cycle frame event for interrupt logic |
| frame_start | output | 1 | First visible pixel strobe |
| frame_end | output | 1 | Last visible pixel strobe |
| paused | output | 1 | Raster held at origin |
| te_evt | output | 1 | One-cycle tearing-effect event |

## Verification
The hardest situation to reach is the pause entry. The request has to be seen on the very last cycle of a frame, and the shadow copy must still accept a new geometry while the raster is frozen. The bench switches to a geometry with zero front porches and a zero vertical back porch. It raises the pause request at the start of that frame and follows a cycle-accurate position model up to the boundary. It then checks the quiet outputs over many paused cycles, withdraws the request, and checks that the restart lands exactly on the origin. Changes to the words in mid-frame are compared against the same model, which takes the new values only at a frame origin.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // Raster sequencer phase
  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_RUN   = 2'd1,
    PH_PAUSE = 2'd2
  } dtg_phase_e;

endpackage

// File: rtl/dtg_rst_sync.sv
module dtg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dtg_axis.sv
module dtg_axis #(
  parameter int SYNC_W  = 8,
  parameter int PORCH_W = 12,
  parameter int ACT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [SYNC_W-1:0]  sync_i,
  input  logic [PORCH_W-1:0] bp_i,
  input  logic [ACT_W-1:0]   act_i,
  input  logic [PORCH_W-1:0] fp_i,
  input  logic               step_i,
  input  logic               hold_i,
  output logic               origin_o,
  output logic               last_o,
  output logic               sync_o,
  output logic               act_o,
  output logic               act_first_o,
  output logic               act_last_o
);

  localparam int CNT_W = ACT_W + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [SYNC_W-1:0]  sync_q, sync_d;
  logic [PORCH_W-1:0] bp_q,   bp_d;
  logic [ACT_W-1:0]   act_q,  act_d;
  logic [PORCH_W-1:0] fp_q,   fp_d;
  logic [CNT_W-1:0]   cnt_q,  cnt_d;

  logic [CNT_W-1:0] edge_bp, edge_act, edge_fp, total;

  // Region boundaries from the shadow copy
  always_comb begin
    edge_bp  = CNT_W'(sync_q);
    edge_act = edge_bp + CNT_W'(bp_q);
    edge_fp  = edge_act + CNT_W'(act_q);
    total    = edge_fp + CNT_W'(fp_q);
  end

  always_comb begin
    last_o      = (total <= ONE) || (cnt_q == total - ONE);
    origin_o    = (cnt_q == '0);
    sync_o      = (cnt_q < edge_bp);
    act_o       = (cnt_q >= edge_act) && (cnt_q < edge_fp);
    act_first_o = (act_q != '0) && (cnt_q == edge_act);
    act_last_o  = (act_q != '0) && (cnt_q == edge_fp - ONE);
  end

  // Next state: shadow copy and position counter
  always_comb begin
    sync_d = sync_q;
    bp_d   = bp_q;
    act_d  = act_q;
    fp_d   = fp_q;
    if (load_i) begin
      sync_d = sync_i;
      bp_d   = bp_i;
      act_d  = act_i;
      fp_d   = fp_i;
    end
    cnt_d = cnt_q;
    if (hold_i)      cnt_d = '0;
    else if (step_i) cnt_d = last_o ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      bp_q   <= '0;
      act_q  <= '0;
      fp_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      bp_q   <= bp_d;
      act_q  <= act_d;
      fp_q   <= fp_d;
      cnt_q  <= cnt_d;
    end
  end

  // R2 / R3: position never leaves the programmed period
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (total != '0) |-> (cnt_q < total));

  // R2 / R3: a step on the final position returns to the origin
  assert_wrap_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !hold_i && last_o) |=> origin_o);

endmodule

// File: rtl/dtg_te_sel.sv
module dtg_te_sel #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pad_sel_i,
  input  logic pad_i,
  input  logic core_i,
  output logic pulse_o
);

  logic              src;
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    src    = pad_sel_i ? pad_i : core_i;
    sync_d = {sync_q[STAGES-2:0], src};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign pulse_o = en_i & sync_q[STAGES-1] & ~prev_q;

  // R10: each event lasts exactly one cycle
  assert_te_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R11: no event while disabled
  assert_te_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pulse_o);

endmodule

// File: rtl/dtg_top.sv
module dtg_top #(
  parameter int ACT_W       = 16,
  parameter int SYNC_W      = 8,
  parameter int PORCH_W     = 12,
  parameter int RST_STAGES  = 2,
  parameter int TE_STAGES   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2*ACT_W-1:0]            size_word,
  input  logic [SYNC_W+2*PORCH_W-1:0]   h_timing,
  input  logic [SYNC_W+2*PORCH_W-1:0]   v_timing,
  input  logic                          halt_en,
  input  logic                          halt_req,
  input  logic                          te_en,
  input  logic                          te_src_pad,
  input  logic                          te_pad,
  input  logic                          te_core,
  output logic                          hsync,
  output logic                          vsync,
  output logic                          de,
  output logic                          vsync_evt,
  output logic                          frame_start,
  output logic                          frame_end,
  output logic                          paused,
  output logic                          te_evt
);

  import dtg_pkg::*;

  localparam int BP_LSB = SYNC_W;
  localparam int FP_LSB = SYNC_W + PORCH_W;
  localparam int AXES   = 2;

  logic       srst_n;
  dtg_phase_e phase_q, phase_d;
  logic       load;
  logic       running;
  logic       halt_on;
  logic       frame_last;

  logic [AXES-1:0] ax_origin, ax_last, ax_sync, ax_act, ax_first, ax_lastact;
  logic [AXES-1:0] ax_step;
  logic [SYNC_W+2*PORCH_W-1:0] ax_word [AXES];
  logic [ACT_W-1:0]            ax_size [AXES];

  dtg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    ax_word[0] = h_timing;
    ax_word[1] = v_timing;
    ax_size[0] = size_word[ACT_W-1:0];
    ax_size[1] = size_word[2*ACT_W-1:ACT_W];
  end

  // Index 0 is the horizontal axis, index 1 the vertical axis
  for (genvar a = 0; a < AXES; a++) begin : g_axis
    dtg_axis #(
      .SYNC_W  (SYNC_W),
      .PORCH_W (PORCH_W),
      .ACT_W   (ACT_W)
    ) u_axis (
      .clk         (clk),
      .rst_n       (srst_n),
      .load_i      (load),
      .sync_i      (ax_word[a][SYNC_W-1:0]),
      .bp_i        (ax_word[a][BP_LSB +: PORCH_W]),
      .act_i       (ax_size[a]),
      .fp_i        (ax_word[a][FP_LSB +: PORCH_W]),
      .step_i      (ax_step[a]),
      .hold_i      (!running),
      .origin_o    (ax_origin[a]),
      .last_o      (ax_last[a]),
      .sync_o      (ax_sync[a]),
      .act_o       (ax_act[a]),
      .act_first_o (ax_first[a]),
      .act_last_o  (ax_lastact[a])
    );
  end

  always_comb begin
    running    = (phase_q == PH_RUN);
    halt_on    = halt_en & halt_req;
    frame_last = ax_last[0] & ax_last[1];
    ax_step[0] = running;
    ax_step[1] = running & ax_last[0];
  end

  // Sequencer next state
  always_comb begin
    phase_d = phase_q;
    load    = 1'b0;
    unique case (phase_q)
      PH_SETUP: begin
        load    = 1'b1;
        phase_d = PH_RUN;
      end
      PH_RUN: begin
        if (frame_last) begin
          load = 1'b1;
          if (halt_on) phase_d = PH_PAUSE;
        end
      end
      PH_PAUSE: begin
        load = 1'b1;
        if (!halt_on) phase_d = PH_RUN;
      end
      default: phase_d = PH_SETUP;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) phase_q <= PH_SETUP;
    else         phase_q <= phase_d;
  end

  always_comb begin
    hsync       = running & ax_sync[0];
    vsync       = running & ax_sync[1];
    de          = running & ax_act[0] & ax_act[1];
    vsync_evt   = running & ax_origin[0] & ax_origin[1];
    frame_start = running & ax_first[0] & ax_first[1];
    frame_end   = running & ax_lastact[0] & ax_lastact[1];
    paused      = (phase_q == PH_PAUSE);
  end

  dtg_te_sel #(.STAGES(TE_STAGES)) u_te (
    .clk       (clk),
    .rst_n     (srst_n),
    .en_i      (te_en),
    .pad_sel_i (te_src_pad),
    .pad_i     (te_pad),
    .core_i    (te_core),
    .pulse_o   (te_evt)
  );

  // R4: the visible region never overlaps a sync region
  assert_de_clear_of_sync_R4: assert property (@(posedge clk) disable iff (!srst_n)
    de |-> (!hsync && !vsync));

  // R5: frame event does not repeat on the next cycle
  assert_evt_single_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (vsync_evt && !frame_last) |=> !vsync_evt);

  // R8: outputs quiet while paused
  assert_paused_quiet_R8: assert property (@(posedge clk) disable iff (!srst_n)
    paused |-> !(hsync || vsync || de || vsync_evt || frame_start || frame_end));

  // R8: pause begins only right after a frame's final cycle
  assert_pause_at_end_R8: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(paused) |-> $past(frame_last));

  // R9: pause requires the enable
  assert_pause_needs_en_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(paused) |-> $past(halt_en && halt_req));

endmodule

// File: tb/tb_dtg_top.sv
`timescale 1ns/1ps
module tb_dtg_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] size_word, h_timing, v_timing;
  logic        halt_en, halt_req, te_en, te_src_pad, te_pad, te_core;
  logic        hsync, vsync, de, vsync_evt, frame_start, frame_end, paused, te_evt;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 0;

  // Driven geometry
  int d_hs, d_hb, d_hw, d_hf, d_vs, d_vb, d_vh, d_vf;
  // Geometry the model is using for the current frame
  int m_hs, m_hb, m_hw, m_hf, m_vs, m_vb, m_vh, m_vf;
  int ph, pv;

  always #2.5 clk = ~clk;

  dtg_top dut (
    .clk(clk), .rst_n(rst_n), .size_word(size_word), .h_timing(h_timing),
    .v_timing(v_timing), .halt_en(halt_en), .halt_req(halt_req), .te_en(te_en),
    .te_src_pad(te_src_pad), .te_pad(te_pad), .te_core(te_core),
    .hsync(hsync), .vsync(vsync), .de(de), .vsync_evt(vsync_evt),
    .frame_start(frame_start), .frame_end(frame_end), .paused(paused), .te_evt(te_evt)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b (h=%0d v=%0d t=%0t)", what, act, exp, ph, pv, $time);
    end
  endtask

  function automatic logic [31:0] pack_t(input int s, input int b, input int f);
    return (32'(s) & 32'hff) | ((32'(b) & 32'hfff) << 8) | ((32'(f) & 32'hfff) << 20);
  endfunction

  task automatic set_cfg(input int hs, input int hb, input int hw, input int hf,
                         input int vs, input int vb, input int vh, input int vf);
    d_hs = hs; d_hb = hb; d_hw = hw; d_hf = hf;
    d_vs = vs; d_vb = vb; d_vh = vh; d_vf = vf;
    h_timing  = pack_t(hs, hb, hf);
    v_timing  = pack_t(vs, vb, vf);
    size_word = (32'(vh) << 16) | (32'(hw) & 32'hffff);
  endtask

  task automatic chk_quiet(input string what);
    chk({what, " hsync"}, hsync, 1'b0);
    chk({what, " vsync"}, vsync, 1'b0);
    chk({what, " de"}, de, 1'b0);
    chk({what, " vsync_evt"}, vsync_evt, 1'b0);
    chk({what, " frame_start"}, frame_start, 1'b0);
    chk({what, " frame_end"}, frame_end, 1'b0);
  endtask

  // Compare one raster cycle against the position model, then advance
  task automatic model_step(input string tag);
    logic e_hs, e_vs, e_ha, e_va, e_fs, e_fe, e_ev;
    if (ph == 0 && pv == 0) begin
      m_hs = d_hs; m_hb = d_hb; m_hw = d_hw; m_hf = d_hf;
      m_vs = d_vs; m_vb = d_vb; m_vh = d_vh; m_vf = d_vf;
    end
    e_hs = (ph < m_hs);
    e_vs = (pv < m_vs);
    e_ha = (ph >= m_hs + m_hb) && (ph < m_hs + m_hb + m_hw);
    e_va = (pv >= m_vs + m_vb) && (pv < m_vs + m_vb + m_vh);
    e_ev = (ph == 0) && (pv == 0);
    e_fs = (m_hw > 0) && (m_vh > 0) && (ph == m_hs + m_hb) && (pv == m_vs + m_vb);
    e_fe = (m_hw > 0) && (m_vh > 0) && (ph == m_hs + m_hb + m_hw - 1) &&
           (pv == m_vs + m_vb + m_vh - 1);
    chk({tag, " R2 hsync"}, hsync, e_hs);
    chk({tag, " R3 vsync"}, vsync, e_vs);
    chk({tag, " R4 de"}, de, e_ha && e_va);
    chk({tag, " R5 vsync_evt"}, vsync_evt, e_ev);
    chk({tag, " R6 frame_start"}, frame_start, e_fs);
    chk({tag, " R6 frame_end"}, frame_end, e_fe);
    chk({tag, " R9 paused"}, paused, 1'b0);
    ph++;
    if (ph == m_hs + m_hb + m_hw + m_hf) begin
      ph = 0;
      pv++;
      if (pv == m_vs + m_vb + m_vh + m_vf) pv = 0;
    end
    @(negedge clk);
  endtask

  task automatic run_to_origin(input string tag);
    model_step(tag);
    while (!(ph == 0 && pv == 0)) model_step(tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    halt_en = 0; halt_req = 0; te_en = 0; te_src_pad = 0; te_pad = 0; te_core = 0;
    set_cfg(2, 3, 4, 1, 1, 2, 3, 1);
    repeat (3) @(negedge clk);
    chk_quiet("R1 in reset");
    chk("R1 in reset paused", paused, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_quiet("R1 sync stage 1");
    @(negedge clk);
    chk_quiet("R1 sync stage 2");
    @(negedge clk);
    ph = 0; pv = 0;
    chk("R1 first counted cycle vsync_evt", vsync_evt, 1'b1);
  endtask

  task automatic t_free_run;
    for (int i = 0; i < 140; i++) model_step("free run");
  endtask

  task automatic t_cfg_boundary;
    for (int i = 0; i < 20; i++) model_step("R7 before switch");
    set_cfg(1, 1, 5, 2, 2, 1, 2, 2);
    for (int i = 0; i < 150; i++) model_step("R7 mid-frame switch");
  endtask

  task automatic t_halt_ignored;
    halt_en = 1'b0;
    halt_req = 1'b1;
    for (int i = 0; i < 90; i++) model_step("R9 halt_en low");
    halt_req = 1'b0;
  endtask

  task automatic t_halt;
    // Zero front porches and zero vertical back porch
    set_cfg(3, 0, 3, 0, 1, 0, 2, 0);
    run_to_origin("R8 finish old geometry");
    halt_en  = 1'b1;
    halt_req = 1'b1;
    run_to_origin("R8 frame before pause");
    for (int i = 0; i < 20; i++) begin
      chk("R8 paused", paused, 1'b1);
      chk_quiet("R8 paused quiet");
      @(negedge clk);
    end
    halt_req = 1'b0;
    @(negedge clk);
    chk("R8 resume vsync_evt", vsync_evt, 1'b1);
    for (int i = 0; i < 48; i++) model_step("R8 after resume");
    halt_en = 1'b0;
  endtask

  task automatic te_expect_pulse(input string tag);
    @(negedge clk); chk({tag, " edge+1"}, te_evt, 1'b0);
    @(negedge clk); chk({tag, " edge+2"}, te_evt, 1'b1);
    @(negedge clk); chk({tag, " edge+3"}, te_evt, 1'b0);
    @(negedge clk); chk({tag, " held"}, te_evt, 1'b0);
  endtask

  task automatic te_expect_none(input string tag);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk(tag, te_evt, 1'b0);
    end
  endtask

  task automatic t_te;
    te_en = 1'b1; te_src_pad = 1'b1;
    repeat (3) @(negedge clk);
    te_core = 1'b1;
    te_expect_none("R10 unselected core ignored");
    te_core = 1'b0;
    repeat (3) @(negedge clk);
    te_pad = 1'b1;
    te_expect_pulse("R10 pad source");
    te_pad = 1'b0;
    repeat (3) @(negedge clk);
    te_src_pad = 1'b0;
    repeat (3) @(negedge clk);
    te_pad = 1'b1;
    te_expect_none("R10 unselected pad ignored");
    te_pad = 1'b0;
    repeat (3) @(negedge clk);
    te_core = 1'b1;
    te_expect_pulse("R10 core source");
    te_core = 1'b0;
    repeat (3) @(negedge clk);
    te_en = 1'b0; te_src_pad = 1'b1;
    repeat (3) @(negedge clk);
    te_pad = 1'b1;
    te_expect_none("R11 disabled");
    te_pad = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_cfg_boundary();
    t_halt_ignored();
    t_halt();
    t_te();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired: run did not complete");
      finish_run();
    end
  end

endmodule